// File: doc/BRIEF.md
# Way-Pointer Replay Mode Controller

This controller steers the way activation of a 4-way set-associative instruction cache so that earlier tag-check outcomes can be reused. It watches branch-target-buffer hits, cache-line fetches, cache misses and front-end redirects. From these events it runs a three-state machine with the states normal, trace and omit. In normal and trace it lets all ways run with full tag comparison. In omit it turns on only the single way that was learned on an earlier pass down the same branch path.

The controller is told about each BTB hit. It receives the branch address, the predicted direction, and the stored way-pointer list for that direction together with a count of valid pointers. A count of zero means the history is missing. In that case the controller remembers the branch and direction, and then logs the hit way of every following line. At the next BTB hit it offers that log for storage. A nonzero count makes the controller play the list back, one pointer per fetched line. Any cache miss drops the controller to normal mode and raises a request to clear all stored pointers.

Top module: `wayreuse_ctrl`

## Requirements
- R1: After reset the mode is normal (`mode_o` encoding: 0 normal, 1 trace, 2 omit), `way_en` is 4'b1111, `rec_we` and `inv_req` are low, and `rec_cnt` is 0.
- R2: In normal and trace mode `way_en` is 4'b1111 and `tag_chk` is high.
- R3: A BTB hit with `wp_cnt` equal to 0 captures `btb_addr` and `btb_taken` into `rec_addr`/`rec_dir`, clears the log (`rec_cnt` 0), and enters trace mode on the next cycle.
- R4: In trace mode, each line fetch without a BTB hit stores `line_hit_way` into log slot k = `rec_cnt` (bits 2k+1:2k of `rec_ptrs`, slot 0 first) and increments `rec_cnt`.
- R5: Once `rec_cnt` reaches NWP, further line fetches in trace mode leave the log and the count unchanged, so the first NWP ways are kept.
- R6: A BTB hit in trace mode with `rec_cnt` nonzero raises `rec_we` in that same cycle, and `rec_addr`, `rec_dir`, `rec_ptrs` and `rec_cnt` present the pending branch and the log. With `rec_cnt` equal to 0, no write is raised.
- R7: A BTB hit with nonzero `wp_cnt` loads `wp_list` (pointer k at bits 2k+1:2k) and enters omit mode. `way_en` is then one-hot on the current pointer, `tag_chk` is low, and each line fetch advances to the next pointer.
- R8: A line fetch that consumes the last valid pointer returns the controller to normal mode, so the next line gets `way_en` 4'b1111.
- R9: A cache miss puts the controller in normal mode on the next cycle and raises `inv_req` for exactly one cycle, one cycle after the miss.
- R10: A redirect in trace or omit mode returns the controller to normal mode and writes nothing. A BTB hit that follows raises no `rec_we`.
- R11: Event priority is cache miss, then redirect, then BTB hit, then line fetch. A line fetched in the same cycle as a BTB hit uses the current `way_en`, but it is neither logged nor consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_fetch | input | 1 | A new cache line is fetched this cycle |
| line_hit_way | input | 2 | Hit way reported by the tag comparators for the fetched line |
| cache_miss | input | 1 | The current fetch missed |
| redirect | input | 1 | Misprediction or front-end redirect |
| btb_hit | input | 1 | BTB hit this cycle |
| btb_addr | input | AW | Address of the hitting branch |
| btb_taken | input | 1 | Predicted direction (1 taken) |
| wp_cnt | input | $clog2(NWP+1) | Valid pointers stored for the predicted direction |
| wp_list | input | 2*NWP | Stored pointers, pointer k at bits 2k+1:2k |
| way_en | output | 4 | Per-way enable for the current line |
| tag_chk | output | 1 | Tag comparison required for the current line |
| mode_o | output | 2 | Current mode |
| rec_we | output | 1 | Request to write the log to pointer storage |
| rec_addr | output | AW | Pending branch address for the write |
| rec_dir | output | 1 | Pending direction for the write |
| rec_ptrs | output | 2*NWP | Logged way pointers |
| rec_cnt | output | $clog2(NWP+1) | Number of logged pointers |
| inv_req | output | 1 | Request to invalidate all stored pointers |

## Verification
The bench builds the controller with NWP=4 and AW=12, so the pointer count is three bits wide. At this size a five-line trace is enough to overrun the log and show the cap. With four ways and four slots, every way index can appear in one played-back list, which checks each one-hot position of `way_en`. The 12-bit address keeps the pending-branch values distinct from vector to vector, so a stale capture would show up at the write port.

// File: rtl/wayreuse_ctrl.sv
module wayreuse_ctrl #(
  parameter int NWP = 4,
  parameter int AW  = 16,
  localparam int CW = $clog2(NWP + 1),
  localparam int PW = 2 * NWP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_fetch,
  input  logic [1:0]    line_hit_way,
  input  logic          cache_miss,
  input  logic          redirect,
  input  logic          btb_hit,
  input  logic [AW-1:0] btb_addr,
  input  logic          btb_taken,
  input  logic [CW-1:0] wp_cnt,
  input  logic [PW-1:0] wp_list,
  output logic [3:0]    way_en,
  output logic          tag_chk,
  output logic [1:0]    mode_o,
  output logic          rec_we,
  output logic [AW-1:0] rec_addr,
  output logic          rec_dir,
  output logic [PW-1:0] rec_ptrs,
  output logic [CW-1:0] rec_cnt,
  output logic          inv_req
);
  localparam logic [1:0] M_NORM  = 2'd0;
  localparam logic [1:0] M_TRACE = 2'd1;
  localparam logic [1:0] M_OMIT  = 2'd2;

  logic [1:0]    mode;
  logic [PW-1:0] rec, play;
  logic [CW-1:0] rcnt, pleft;
  logic [AW-1:0] paddr;
  logic          pdir, inv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode  <= M_NORM;
      rec   <= '0;
      play  <= '0;
      rcnt  <= '0;
      pleft <= '0;
      paddr <= '0;
      pdir  <= 1'b0;
      inv_q <= 1'b0;
    end else begin
      inv_q <= cache_miss;
      if (cache_miss || redirect) begin
        mode <= M_NORM;
      end else if (btb_hit) begin
        if (wp_cnt != '0) begin
          play  <= wp_list;
          pleft <= wp_cnt;
          mode  <= M_OMIT;
        end else begin
          paddr <= btb_addr;
          pdir  <= btb_taken;
          rec   <= '0;
          rcnt  <= '0;
          mode  <= M_TRACE;
        end
      end else if (line_fetch) begin
        if (mode == M_TRACE && rcnt < CW'(NWP)) begin
          rec[{rcnt, 1'b0} +: 2] <= line_hit_way;
          rcnt <= rcnt + 1'b1;
        end else if (mode == M_OMIT) begin
          play  <= play >> 2;
          pleft <= pleft - 1'b1;
          if (pleft == CW'(1)) mode <= M_NORM;
        end
      end
    end
  end

  assign way_en   = (mode == M_OMIT) ? (4'b0001 << play[1:0]) : 4'b1111;
  assign tag_chk  = (mode != M_OMIT);
  assign mode_o   = mode;
  assign rec_we   = btb_hit && !cache_miss && !redirect && mode == M_TRACE && rcnt != '0;
  assign rec_addr = paddr;
  assign rec_dir  = pdir;
  assign rec_ptrs = rec;
  assign rec_cnt  = rcnt;
  assign inv_req  = inv_q;

  assert_omit_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_OMIT |-> $countones(way_en) == 1);
  assert_full_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode != M_OMIT |-> way_en == 4'b1111);
  assert_omit_has_ptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_OMIT |-> pleft != '0);
  assert_log_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rcnt <= CW'(NWP));
  assert_miss_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cache_miss |=> (mode == M_NORM && inv_req));
  assert_redirect_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && !cache_miss) |=> mode == M_NORM);
  assert_write_restarts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rec_we |=> (mode == M_OMIT || rcnt == '0));
endmodule

// File: tb/wayreuse_ctrl_tb.sv
module wayreuse_ctrl_tb_top;
  localparam int NWP = 4;
  localparam int AW  = 12;
  localparam int NV  = 23;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_fetch = 0, cache_miss = 0, redirect = 0, btb_hit = 0, btb_taken = 0;
  logic [1:0] line_hit_way = '0;
  logic [AW-1:0] btb_addr = '0;
  logic [2:0] wp_cnt = '0;
  logic [7:0] wp_list = '0;
  logic [3:0] way_en;
  logic tag_chk, rec_we, rec_dir, inv_req;
  logic [1:0] mode_o;
  logic [AW-1:0] rec_addr;
  logic [7:0] rec_ptrs;
  logic [2:0] rec_cnt;
  int checks = 0, fails = 0, cycles = 0;

  always #10 clk = ~clk;

  wayreuse_ctrl #(.NWP(NWP), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_fetch(line_fetch), .line_hit_way(line_hit_way),
    .cache_miss(cache_miss), .redirect(redirect), .btb_hit(btb_hit), .btb_addr(btb_addr),
    .btb_taken(btb_taken), .wp_cnt(wp_cnt), .wp_list(wp_list), .way_en(way_en),
    .tag_chk(tag_chk), .mode_o(mode_o), .rec_we(rec_we), .rec_addr(rec_addr),
    .rec_dir(rec_dir), .rec_ptrs(rec_ptrs), .rec_cnt(rec_cnt), .inv_req(inv_req));

  // {req, {miss,redir,btb,lf}, taken, wp_cnt, wp_list, hit_way, exp_way_en, exp_rec_we, exp_mode_after}
  localparam logic [28:0] VEC [NV] = '{
    {4'd2,  4'b0001, 1'b0, 3'd0, 8'h00, 2'd2, 4'b1111, 1'b0, 2'd0}, // R2 normal fetch
    {4'd3,  4'b0010, 1'b1, 3'd0, 8'h00, 2'd0, 4'b1111, 1'b0, 2'd1}, // R3 enter trace
    {4'd4,  4'b0001, 1'b0, 3'd0, 8'h00, 2'd1, 4'b1111, 1'b0, 2'd1}, // R4 log 1
    {4'd4,  4'b0001, 1'b0, 3'd0, 8'h00, 2'd3, 4'b1111, 1'b0, 2'd1}, // R4 log 3
    {4'd4,  4'b0001, 1'b0, 3'd0, 8'h00, 2'd0, 4'b1111, 1'b0, 2'd1}, // R4 log 0
    {4'd6,  4'b0010, 1'b0, 3'd3, 8'h36, 2'd0, 4'b1111, 1'b1, 2'd2}, // R6 write, load 2,1,3
    {4'd7,  4'b0001, 1'b0, 3'd0, 8'h00, 2'd0, 4'b0100, 1'b0, 2'd2}, // R7 way 2
    {4'd7,  4'b0001, 1'b0, 3'd0, 8'h00, 2'd0, 4'b0010, 1'b0, 2'd2}, // R7 way 1
    {4'd8,  4'b0001, 1'b0, 3'd0, 8'h00, 2'd0, 4'b1000, 1'b0, 2'd0}, // R8 last pointer
    {4'd8,  4'b0001, 1'b0, 3'd0, 8'h00, 2'd0, 4'b1111, 1'b0, 2'd0}, // R8 full access
    {4'd7,  4'b0010, 1'b1, 3'd2, 8'h0C, 2'd0, 4'b1111, 1'b0, 2'd2}, // R7 load 0,3
    {4'd7,  4'b0001, 1'b0, 3'd0, 8'h00, 2'd0, 4'b0001, 1'b0, 2'd2}, // R7 way 0
    {4'd9,  4'b1000, 1'b0, 3'd0, 8'h00, 2'd0, 4'b1000, 1'b0, 2'd0}, // R9 miss in omit
    {4'd3,  4'b0010, 1'b0, 3'd0, 8'h00, 2'd0, 4'b1111, 1'b0, 2'd1}, // R3 trace again
    {4'd4,  4'b0001, 1'b0, 3'd0, 8'h00, 2'd2, 4'b1111, 1'b0, 2'd1}, // R4 log 2
    {4'd10, 4'b0100, 1'b0, 3'd0, 8'h00, 2'd0, 4'b1111, 1'b0, 2'd0}, // R10 redirect
    {4'd10, 4'b0010, 1'b0, 3'd0, 8'h00, 2'd0, 4'b1111, 1'b0, 2'd1}, // R10 no write after abort
    {4'd6,  4'b0010, 1'b0, 3'd0, 8'h00, 2'd0, 4'b1111, 1'b0, 2'd1}, // R6 empty log no write
    {4'd11, 4'b0011, 1'b0, 3'd1, 8'h01, 2'd3, 4'b1111, 1'b0, 2'd2}, // R11 fetch with btb
    {4'd11, 4'b0001, 1'b0, 3'd0, 8'h00, 2'd0, 4'b0010, 1'b0, 2'd0}, // R11 not logged
    {4'd11, 4'b1110, 1'b0, 3'd1, 8'h02, 2'd0, 4'b1111, 1'b0, 2'd0}, // R11 miss wins
    {4'd3,  4'b0010, 1'b1, 3'd0, 8'h00, 2'd0, 4'b1111, 1'b0, 2'd1}, // R3 trace
    {4'd11, 4'b0110, 1'b0, 3'd1, 8'h03, 2'd0, 4'b1111, 1'b0, 2'd0}  // R11 redirect over btb
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    {line_fetch, cache_miss, redirect, btb_hit, btb_taken} = '0;
    wp_cnt = '0; wp_list = '0; line_hit_way = '0;
  endtask

  task automatic step(input logic b, input logic lf, input logic [1:0] hw, input logic [AW-1:0] a, input logic tk);
    @(negedge clk);
    idle();
    btb_hit = b; line_fetch = lf; line_hit_way = hw; btb_addr = a; btb_taken = tk;
  endtask

  function automatic string rtag(input int n);
    return $sformatf("R%0d", n);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected <= 5000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", "mode", 32'(mode_o), 0);
    chk("R1", "way_en", 32'(way_en), 32'hF);
    chk("R1", "rec_we", 32'(rec_we), 0);
    chk("R1", "inv_req", 32'(inv_req), 0);
    chk("R1", "rec_cnt", 32'(rec_cnt), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [28:0] v;
      v = VEC[i];
      @(negedge clk);
      {cache_miss, redirect, btb_hit, line_fetch} = v[24:21];
      btb_taken = v[20]; wp_cnt = v[19:17]; wp_list = v[16:9]; line_hit_way = v[8:7];
      btb_addr = AW'(12'h100 + i);
      #3;
      chk(rtag(int'(v[28:25])), $sformatf("vec %0d way_en", i), 32'(way_en), 32'(v[6:3]));
      chk(rtag(int'(v[28:25])), $sformatf("vec %0d tag_chk", i), 32'(tag_chk), 32'(v[6:3] == 4'hF));
      chk(rtag(int'(v[28:25])), $sformatf("vec %0d rec_we", i), 32'(rec_we), 32'(v[2]));
      @(posedge clk); #3;
      chk(rtag(int'(v[28:25])), $sformatf("vec %0d mode", i), 32'(mode_o), 32'(v[1:0]));
    end

    // R3 pending capture, then R4/R5 log with overflow
    step(1'b1, 1'b0, 2'd0, 12'hABC, 1'b1);
    @(posedge clk); #3;
    chk("R3", "rec_addr", 32'(rec_addr), 32'hABC);
    chk("R3", "rec_dir", 32'(rec_dir), 1);
    chk("R3", "rec_cnt", 32'(rec_cnt), 0);
    step(1'b0, 1'b1, 2'd1, 12'h000, 1'b0);
    step(1'b0, 1'b1, 2'd2, 12'h000, 1'b0);
    step(1'b0, 1'b1, 2'd3, 12'h000, 1'b0);
    step(1'b0, 1'b1, 2'd0, 12'h000, 1'b0);
    @(posedge clk); #3;
    chk("R4", "rec_ptrs", 32'(rec_ptrs), 32'h39);
    chk("R4", "rec_cnt", 32'(rec_cnt), 4);
    step(1'b0, 1'b1, 2'd3, 12'h000, 1'b0);
    @(posedge clk); #3;
    chk("R5", "rec_ptrs", 32'(rec_ptrs), 32'h39);
    chk("R5", "rec_cnt", 32'(rec_cnt), 4);
    // R6 write port contents on the closing BTB hit
    step(1'b1, 1'b0, 2'd0, 12'h555, 1'b0);
    #3;
    chk("R6", "rec_we", 32'(rec_we), 1);
    chk("R6", "rec_addr", 32'(rec_addr), 32'hABC);
    chk("R6", "rec_dir", 32'(rec_dir), 1);
    chk("R6", "rec_ptrs", 32'(rec_ptrs), 32'h39);
    chk("R6", "rec_cnt", 32'(rec_cnt), 4);
    // R9 invalidate pulse timing
    @(negedge clk); idle(); cache_miss = 1'b1;
    #3;
    chk("R9", "inv_req same cycle", 32'(inv_req), 0);
    @(negedge clk); idle();
    #3;
    chk("R9", "inv_req next cycle", 32'(inv_req), 1);
    chk("R9", "mode", 32'(mode_o), 0);
    @(negedge clk);
    #3;
    chk("R9", "inv_req one cycle", 32'(inv_req), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule